// File: doc/BRIEF.md
# Auxiliary Control Register with Timer Toggle Outputs

This block is an 8-bit control register for a small microcontroller. It sits on the special-function register bus. It holds several unrelated control levels: a data-pointer select, a clock low-power select, two toggle enables, a break-reset enable and a software-reset request. From these it drives a handful of side outputs. Software writes the register through the bus and can read it back at any time. There is also a read-modify-write increment strobe. Bit 2 is a constant zero, so an increment always flips the pointer-select bit and never carries into the upper control bits.

Two square-wave outputs invert on Timer 0 and Timer 1 overflow strobes when their enables are set, giving half the overflow rate. Writing the software-reset bit produces a one-cycle reset request. When the break-reset enable is set, a UART break strobe produces a one-cycle reset request together with a request for in-system-programming mode. Either request makes the register and both toggle outputs return to their reset state on the next cycle, just as a chip reset would.

Top module: `aux_ctrl_reg`

## Requirements
- R1: While `rst_n` is low and after it is released, `rdata` is 0x00 and every output is 0.
- R2: A write stores `wdata` with bit 2 forced to 0. `rdata` shows the stored value from the next cycle. Bit 2 of `rdata` is always 0.
- R3: An increment (`inc_en` high, `wr_en` low) adds 1 into bits 1:0 only, wrapping from 3 to 0. Bit 0 therefore always inverts, and bits 7:3 stay unchanged.
- R4: Bit 1 has no effect on any output other than its own read-back.
- R5: Writing a 1 to bit 3 raises `sw_rst` for exactly one cycle. On the following cycle the register and both toggle outputs are 0 again.
- R6: While bit 4 is 1, `tgl0_out` inverts one cycle after each `t0_ovf` strobe.
- R7: While bit 5 is 1, `tgl1_out` inverts one cycle after each `t1_ovf` strobe.
- R8: A toggle output holds its value while its enable bit is 0.
- R9: `brk_det` with bit 6 set raises `brk_rst` and `isp_req` together for one cycle, and the next cycle clears all state. With bit 6 clear, `brk_det` has no effect.
- R10: `dptr_sel` follows bit 0 and `clk_lowpwr` follows bit 7.
- R11: When `wr_en` and `inc_en` are both high in the same cycle, the write takes effect and the increment is dropped.
- R12: During the cycle in which a reset request (`sw_rst` or `brk_rst`) is high, writes, increments and overflow strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| inc_en | input | 1 | Increment strobe |
| t0_ovf | input | 1 | Timer 0 overflow strobe |
| t1_ovf | input | 1 | Timer 1 overflow strobe |
| brk_det | input | 1 | UART break detected strobe |
| rdata | output | 8 | Register read-back |
| dptr_sel | output | 1 | Data-pointer select level |
| clk_lowpwr | output | 1 | Clock low-power select level |
| tgl0_out | output | 1 | Timer 0 toggle output |
| tgl1_out | output | 1 | Timer 1 toggle output |
| sw_rst | output | 1 | Software reset request pulse |
| brk_rst | output | 1 | Break-triggered reset request pulse |
| isp_req | output | 1 | Programming-mode request pulse |

## Verification
The bench builds the block with its default `UNUSED_READBACK = 1`, so bit 1 reads back as written. This lets the bench see the carry from bit 0 into bit 1 during an increment, and check that bit 1 never spills into bit 2. With this setting, a write of bit 1 can be confirmed at the read port while the bench checks that no other output moves. Random writes set the reset bit only rarely. This leaves long stretches in which the toggle enables and overflow strobes interact, and it still reaches the self-clearing reset path many times.

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg #(
  parameter bit UNUSED_READBACK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       inc_en,
  input  logic       t0_ovf,
  input  logic       t1_ovf,
  input  logic       brk_det,
  output logic [7:0] rdata,
  output logic       dptr_sel,
  output logic       clk_lowpwr,
  output logic       tgl0_out,
  output logic       tgl1_out,
  output logic       sw_rst,
  output logic       brk_rst,
  output logic       isp_req
);

  logic [7:0] ctl;
  logic       brk_q, tq0, tq1;

  wire        clr      = ctl[3] | brk_q;
  wire  [7:0] wr_val   = wdata & 8'hFB;
  wire  [1:0] low_sum  = ctl[1:0] + 2'd1;
  wire  [7:0] inc_val  = {ctl[7:3], 1'b0, low_sum};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      brk_q <= 1'b0;
      tq0   <= 1'b0;
      tq1   <= 1'b0;
    end else if (clr) begin
      ctl   <= '0;
      brk_q <= 1'b0;
      tq0   <= 1'b0;
      tq1   <= 1'b0;
    end else begin
      if (wr_en)       ctl <= wr_val;
      else if (inc_en) ctl <= inc_val;
      tq0   <= tq0 ^ (ctl[4] & t0_ovf);
      tq1   <= tq1 ^ (ctl[5] & t1_ovf);
      brk_q <= brk_det & ctl[6];
    end
  end

  assign rdata      = {ctl[7:3], 1'b0, UNUSED_READBACK ? ctl[1] : 1'b0, ctl[0]};
  assign dptr_sel   = ctl[0];
  assign clk_lowpwr = ctl[7];
  assign tgl0_out   = tq0;
  assign tgl1_out   = tq1;
  assign sw_rst     = ctl[3];
  assign brk_rst    = brk_q;
  assign isp_req    = brk_q;

  p_inc_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_en && !sw_rst && !brk_rst) |=> (rdata[0] != $past(rdata[0])));

  p_inc_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_en && !sw_rst && !brk_rst) |=> (rdata[7:2] == $past(rdata[7:2])));

  p_srst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (rdata == 8'h00 && !sw_rst && !tgl0_out && !tgl1_out));

  p_tgl0_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4] && t0_ovf && !sw_rst && !brk_rst) |=> (tgl0_out != $past(tgl0_out)));

  p_tgl1_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[5] && t1_ovf && !sw_rst && !brk_rst) |=> (tgl1_out != $past(tgl1_out)));

  p_tgl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[4] && !sw_rst && !brk_rst) |=> $stable(tgl0_out));

  p_brk_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && rdata[6] && !sw_rst && !brk_rst) |=> (brk_rst && isp_req));

  p_brk_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[6]) |=> !brk_rst);

  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_rst && !brk_rst) |=> (rdata == ($past(wdata) & 8'hFB)));

endmodule

// File: tb/aux_ctrl_reg_bench.sv
module aux_ctrl_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, inc_en = 1'b0, t0_ovf = 1'b0, t1_ovf = 1'b0, brk_det = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic dptr_sel, clk_lowpwr, tgl0_out, tgl1_out, sw_rst, brk_rst, isp_req;

  int errors = 0;
  int checks = 0;

  logic [7:0] m_reg = 8'h00;
  logic m_t0 = 1'b0, m_t1 = 1'b0, m_brk = 1'b0;

  always #2 clk = ~clk;

  aux_ctrl_reg u_aux_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .inc_en(inc_en),
    .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .brk_det(brk_det), .rdata(rdata),
    .dptr_sel(dptr_sel), .clk_lowpwr(clk_lowpwr), .tgl0_out(tgl0_out),
    .tgl1_out(tgl1_out), .sw_rst(sw_rst), .brk_rst(brk_rst), .isp_req(isp_req)
  );

  function automatic logic [7:0] inc_model(logic [7:0] v);
    logic [1:0] lo;
    lo = (v[1:0] == 2'b11) ? 2'b00 : v[1:0] + 2'b01;
    return {v[7:3], 1'b0, lo};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 rdata", rdata, m_reg);
    chk("R10 dptr_sel", {7'd0, dptr_sel}, {7'd0, m_reg[0]});
    chk("R10 clk_lowpwr", {7'd0, clk_lowpwr}, {7'd0, m_reg[7]});
    chk("R6 tgl0_out", {7'd0, tgl0_out}, {7'd0, m_t0});
    chk("R7 tgl1_out", {7'd0, tgl1_out}, {7'd0, m_t1});
    chk("R5 sw_rst", {7'd0, sw_rst}, {7'd0, m_reg[3]});
    chk("R9 brk_rst", {7'd0, brk_rst}, {7'd0, m_brk});
    chk("R9 isp_req", {7'd0, isp_req}, {7'd0, m_brk});
  endtask

  task automatic step(logic w, logic [7:0] d, logic inc, logic a, logic b, logic k);
    wr_en = w; wdata = d; inc_en = inc; t0_ovf = a; t1_ovf = b; brk_det = k;
    @(posedge clk);
    if (m_reg[3] || m_brk) begin
      m_reg = 8'h00; m_t0 = 1'b0; m_t1 = 1'b0; m_brk = 1'b0;
    end else begin
      m_t0  = m_t0 ^ (m_reg[4] & a);
      m_t1  = m_t1 ^ (m_reg[5] & b);
      m_brk = k & m_reg[6];
      if (w)        m_reg = d & 8'hFB;
      else if (inc) m_reg = inc_model(m_reg);
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset outs", {1'b0, dptr_sel, clk_lowpwr, tgl0_out, tgl1_out, sw_rst, brk_rst, isp_req}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    step(1, 8'hF7, 0, 0, 0, 0);
    chk("R2 bit2 masked", rdata, 8'hF3);
    step(0, 8'h00, 1, 0, 0, 0);
    chk("R3 wrap 11->00", rdata, 8'hF0);
    step(0, 8'h00, 1, 0, 0, 0);
    chk("R3 flip dptr", rdata, 8'hF1);
    step(1, 8'h80, 1, 0, 0, 0);
    chk("R11 write wins", rdata, 8'h80);

    step(1, 8'h30, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0);
    chk("R6 toggle", {7'd0, tgl0_out}, 8'h01);
    chk("R7 toggle", {7'd0, tgl1_out}, 8'h01);
    step(1, 8'h00, 0, 0, 0, 0);
    step(0, 8'h00, 0, 1, 1, 0);
    chk("R8 hold0", {7'd0, tgl0_out}, 8'h01);
    chk("R8 hold1", {7'd0, tgl1_out}, 8'h01);

    snap = {1'b0, dptr_sel, clk_lowpwr, tgl0_out, tgl1_out, sw_rst, brk_rst, isp_req};
    step(1, 8'h02, 0, 0, 0, 0);
    chk("R4 bit1 readback", rdata, 8'h02);
    chk("R4 bit1 no effect", {1'b0, dptr_sel, clk_lowpwr, tgl0_out, tgl1_out, sw_rst, brk_rst, isp_req}, snap);

    step(1, 8'h39, 0, 0, 0, 0);
    chk("R5 pulse", {7'd0, sw_rst}, 8'h01);
    step(1, 8'hC1, 1, 1, 1, 0);
    chk("R5 cleared", rdata, 8'h00);
    chk("R12 ignored during clear", {6'd0, tgl0_out, tgl1_out}, 8'h00);

    step(1, 8'h01, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1);
    chk("R9 no enable", {6'd0, brk_rst, isp_req}, 8'h00);
    step(1, 8'h41, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1);
    chk("R9 req", {6'd0, brk_rst, isp_req}, 8'h03);
    step(0, 8'h00, 0, 0, 0, 0);
    chk("R9 clear", rdata, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ((($urandom) & 32'hF) != 0) d[3] = 1'b0;
      step(($urandom % 4) == 0, d, ($urandom % 3) == 0, ($urandom % 2) == 0,
           ($urandom % 2) == 0, ($urandom % 16) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule